// File: doc/BRIEF.md
# Concurrent-Write Conflict Resolver

Several requesters may each present one write in the same round, and more than one may aim at the same memory address. This block turns such a batch into a list of memory writes with no conflicts, so that no address is written more than once per round. Each requester's (address, value) pair is tagged with its index and placed in a slot of its own. The slots go through a pipelined odd-even merge sort on the key {invalid, address, index}. After sorting, only the first slot of each equal-address run is allowed to produce a write.

The write value for a contested address depends on a policy code captured at the start of the round. The block can let the lowest-index requester win. It can suppress the write, or write a reserved failure value, when the competing values disagree. It can also write the sum, maximum or minimum of all competing values. The writes come out one per cycle on a strobe with its address and value, in ascending address order. A one-cycle done pulse closes the round. The memory itself lives outside the block.

Top module: `cw_resolver`

## Requirements
- R1: After reset, `wr_en` and `done` are low.
- R2: A round starts when `start` is high at a clock edge while no round is running. With P = 8, the first write strobe is visible after the 7th clock edge that follows the edge sampling `start`.
- R3: Each address that has at least one valid request receives at most one write per round. The writes come out on consecutive cycles in strictly ascending address order. A request with its valid bit low never causes a write.
- R4: Policy code 0 writes the value of the lowest-index requester among those sharing the address. Codes 6 and 7 behave the same as code 0.
- R5: Policy code 1 writes the shared value when all competing values are equal. When they differ, the address gets no write.
- R6: Policy code 2 writes the shared value when all competing values are equal. When they differ, it writes the parameter `FAIL_VAL`, which is all ones by default.
- R7: Policy code 3 writes the sum of all competing values, modulo 2^DW.
- R8: Policy code 4 writes the unsigned maximum of the competing values. Policy code 5 writes the unsigned minimum.
- R9: `done` pulses for exactly one cycle, in the cycle right after the last write strobe. If a round produces no writes, `done` is visible after the 8th edge following the start edge (P = 8). `wr_en` is never high in the same cycle as `done`.
- R10: A `start` that arrives while a round is running is ignored, together with the inputs that come with it. A `start` in the `done` cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture the request batch and begin a round |
| policy | input | 3 | Merge policy code, captured with start |
| req_valid | input | P | Valid bit per requester |
| req_addr | input | P*AW | Addresses, requester i in bits [i*AW +: AW] |
| req_data | input | P*DW | Values, requester i in bits [i*DW +: DW] |
| wr_en | output | 1 | Write strobe toward memory |
| wr_addr | output | AW | Write address |
| wr_data | output | DW | Write value |
| done | output | 1 | One-cycle end-of-round pulse |

## Verification
The hardest cases to reach are rounds where a policy's decision rests on a whole equal-address run. Examples are a run of all eight requesters with one dissenting value, a run whose sum overflows, and a round in which every run is suppressed so `done` must follow with no strobe at all. Directed batches build each of these on purpose. Random rounds then draw addresses from only four values, so long runs and mixed valid bits occur often. A start pulse with different data is injected in the middle of a round, and each round is begun in the `done` cycle of the round before. This exercises both the busy-ignore rule and back-to-back acceptance, while every cycle is compared against the reference timeline.

// File: rtl/cw_resolver.sv
module cw_resolver #(
  parameter int P = 8,
  parameter int AW = 8,
  parameter int DW = 16,
  parameter logic [DW-1:0] FAIL_VAL = {DW{1'b1}}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2:0]      policy,
  input  logic [P-1:0]    req_valid,
  input  logic [P*AW-1:0] req_addr,
  input  logic [P*DW-1:0] req_data,
  output logic            wr_en,
  output logic [AW-1:0]   wr_addr,
  output logic [DW-1:0]   wr_data,
  output logic            done
);
  localparam int LG = $clog2(P);
  localparam int L  = LG * (LG + 1) / 2;
  localparam int IW = (LG > 0) ? LG : 1;
  localparam int KW = 1 + AW + IW;
  localparam int EW = KW + DW;

  function automatic int lay_p(int l);
    int idx, res;
    idx = 0; res = 1;
    for (int p = 1; p < P; p = p * 2)
      for (int k = p; k >= 1; k = k / 2) begin
        if (idx == l) res = p;
        idx++;
      end
    return res;
  endfunction

  function automatic int lay_k(int l);
    int idx, res;
    idx = 0; res = 1;
    for (int p = 1; p < P; p = p * 2)
      for (int k = p; k >= 1; k = k / 2) begin
        if (idx == l) res = k;
        idx++;
      end
    return res;
  endfunction

  function automatic bit is_lo(int a, int p, int k);
    return (a >= k % p) && (((a - k % p) % (2 * k)) < k) && (a + k < P) &&
           ((a / (2 * p)) == ((a + k) / (2 * p)));
  endfunction

  logic            take, busy, emit;
  logic [2:0]      pol_q;
  logic [L:0]      vld;
  logic [EW-1:0]   stg [L+1][P];
  logic [P-1:0]    mask, lead;
  logic [AW-1:0]   ra [P];
  logic [DW-1:0]   rv [P], mval [P];
  logic            fv [P];
  logic [AW-1:0]   fa [P];
  logic [DW-1:0]   fd [P];
  logic [IW-1:0]   sel;

  assign take = start && !busy;

  for (genvar e = 0; e < P; e++) begin : g_in
    always_ff @(posedge clk)
      if (take) stg[0][e] <= {~req_valid[e], req_addr[e*AW +: AW], IW'(e), req_data[e*DW +: DW]};
  end

  for (genvar l = 0; l < L; l++) begin : g_lay
    localparam int LP = lay_p(l);
    localparam int LK = lay_k(l);
    for (genvar e = 0; e < P; e++) begin : g_el
      if (is_lo(e, LP, LK)) begin : g_lo
        always_ff @(posedge clk)
          stg[l+1][e] <= (stg[l][e][EW-1:DW] > stg[l][e+LK][EW-1:DW]) ? stg[l][e+LK] : stg[l][e];
      end else if (e >= LK && is_lo(e - LK, LP, LK)) begin : g_hi
        always_ff @(posedge clk)
          stg[l+1][e] <= (stg[l][e-LK][EW-1:DW] > stg[l][e][EW-1:DW]) ? stg[l][e-LK] : stg[l][e];
      end else begin : g_pass
        always_ff @(posedge clk) stg[l+1][e] <= stg[l][e];
      end
    end
  end

  for (genvar e = 0; e < P; e++) begin : g_fin
    assign fv[e] = !stg[L][e][EW-1];
    assign fa[e] = stg[L][e][EW-2 -: AW];
    assign fd[e] = stg[L][e][DW-1:0];
  end

  always_comb begin
    for (int s = 0; s < P; s++) begin
      logic cont, agree, first;
      logic [DW-1:0] sm, mx, mn;
      cont = 1'b1; agree = 1'b1; sm = fd[s]; mx = fd[s]; mn = fd[s];
      for (int t = s + 1; t < P; t++) begin
        if (cont && fv[t] && fa[t] == fa[s]) begin
          agree = agree && (fd[t] == fd[s]);
          sm = sm + fd[t];
          if (fd[t] > mx) mx = fd[t];
          if (fd[t] < mn) mn = fd[t];
        end else cont = 1'b0;
      end
      first = fv[s] && ((s == 0) || (fa[(s == 0) ? 0 : s - 1] != fa[s]));
      lead[s] = first;
      mval[s] = fd[s];
      case (pol_q)
        3'd1: lead[s] = first && agree;
        3'd2: mval[s] = agree ? fd[s] : FAIL_VAL;
        3'd3: mval[s] = sm;
        3'd4: mval[s] = mx;
        3'd5: mval[s] = mn;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; emit <= 1'b0; done <= 1'b0;
      mask <= '0; vld <= '0; pol_q <= '0;
    end else begin
      done <= 1'b0;
      vld <= {vld[L-1:0], take};
      if (take) begin
        busy <= 1'b1;
        pol_q <= policy;
      end
      if (vld[L]) begin
        mask <= lead;
        emit <= 1'b1;
      end else if (emit) begin
        mask <= mask & (mask - 1'b1);
        if ((mask & (mask - 1'b1)) == '0) begin
          emit <= 1'b0;
          done <= 1'b1;
          busy <= 1'b0;
        end
      end
    end
  end

  for (genvar e = 0; e < P; e++) begin : g_res
    always_ff @(posedge clk)
      if (vld[L]) begin
        ra[e] <= fa[e];
        rv[e] <= mval[e];
      end
  end

  always_comb begin
    sel = '0;
    for (int i = P - 1; i >= 0; i--)
      if (mask[i]) sel = IW'(i);
  end

  assign wr_en   = emit && (mask != '0);
  assign wr_addr = ra[sel];
  assign wr_data = rv[sel];

  for (genvar s = 0; s < P - 1; s++) begin : g_sorted
    p_sorted_r3: assert property (@(posedge clk) disable iff (!rst_n)
      vld[L] |-> stg[L][s][EW-1:DW] < stg[L][s+1][EW-1:DW]);
  end

  p_addr_rising_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && $past(wr_en) |-> wr_addr > $past(wr_addr));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_en);

  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !done |=> $stable(pol_q));
endmodule

// File: tb/cw_resolver_tb.sv
module cw_resolver_tb_top;
  localparam int P = 8;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int CLK_PERIOD = 10;
  localparam int LG = $clog2(P);
  localparam int LAT = LG * (LG + 1) / 2 + 1;
  localparam int FAILV = (1 << DW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] policy = '0;
  logic [P-1:0] req_valid = '0;
  logic [P*AW-1:0] req_addr = '0;
  logic [P*DW-1:0] req_data = '0;
  logic wr_en, done;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  int ta [P];
  int td [P];
  logic [P-1:0] tv;
  int eaddr [$];
  int edata [$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  cw_resolver #(.P(P), .AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .policy(policy),
    .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done));

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model(input int pol);
    eaddr.delete();
    edata.delete();
    for (int x = 0; x < (1 << AW); x++) begin
      int cnt, first, sm, mx, mn;
      bit agree;
      cnt = 0; first = 0; sm = 0; mx = 0; mn = 0; agree = 1'b1;
      for (int i = 0; i < P; i++)
        if (tv[i] && ta[i] == x) begin
          if (cnt == 0) begin first = td[i]; mx = td[i]; mn = td[i]; end
          else if (td[i] != first) agree = 1'b0;
          sm = (sm + td[i]) % (1 << DW);
          if (td[i] > mx) mx = td[i];
          if (td[i] < mn) mn = td[i];
          cnt++;
        end
      if (cnt > 0) begin
        case (pol)
          1: if (agree) begin eaddr.push_back(x); edata.push_back(first); end
          2: begin eaddr.push_back(x); edata.push_back(agree ? first : FAILV); end
          3: begin eaddr.push_back(x); edata.push_back(sm); end
          4: begin eaddr.push_back(x); edata.push_back(mx); end
          5: begin eaddr.push_back(x); edata.push_back(mn); end
          default: begin eaddr.push_back(x); edata.push_back(first); end
        endcase
      end
    end
  endtask

  task automatic round(input string tag, input int pol, input bit poke);
    int n, last;
    model(pol);
    n = eaddr.size();
    last = LAT + ((n > 0) ? n : 1);
    policy = 3'(pol);
    req_valid = tv;
    for (int i = 0; i < P; i++) begin
      req_addr[i*AW +: AW] = AW'(ta[i]);
      req_data[i*DW +: DW] = DW'(td[i]);
    end
    start = 1'b1;
    for (int c = 0; c <= last; c++) begin
      bit e_en;
      @(negedge clk);
      start = 1'b0;
      if (poke && c == 2) begin
        start = 1'b1;
        policy = 3'd3;
        req_valid = '1;
        req_addr = '0;
        req_data = '1;
      end
      e_en = (c >= LAT) && (c < LAT + n);
      chk(wr_en == e_en, tag, "wr_en", int'(wr_en), int'(e_en));
      if (e_en && wr_en) begin
        chk(int'(wr_addr) == eaddr[c-LAT], tag, "wr_addr", int'(wr_addr), eaddr[c-LAT]);
        chk(int'(wr_data) == edata[c-LAT], tag, "wr_data", int'(wr_data), edata[c-LAT]);
      end
      chk(done == (c == last), tag, "done", int'(done), int'(c == last));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(wr_en == 1'b0, "R1", "wr_en in reset", int'(wr_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wr_en == 1'b0, "R1", "wr_en", int'(wr_en), 0);
    chk(done == 1'b0, "R1", "done", int'(done), 0);

    // R2 R3 R4: lowest index wins, latency and order
    tv = '1;
    ta = '{5, 3, 5, 3, 9, 5, 1, 3};
    td = '{1, 18, 35, 52, 69, 86, 103, 120};
    round("R4", 0, 1'b0);
    round("R4", 7, 1'b0);
    round("R2", 6, 1'b0);

    // R5 R6: agreement and disagreement
    ta = '{2, 2, 4, 4, 6, 6, 6, 7};
    td = '{10, 10, 11, 12, 13, 13, 13, 99};
    round("R5", 1, 1'b0);
    round("R6", 2, 1'b0);

    // R7 sum with wrap
    ta = '{1, 1, 1, 2, 2, 3, 1, 1};
    td = '{16'hF000, 16'hF000, 16'h0100, 5, 6, 7, 16'h1000, 1};
    round("R7", 3, 1'b0);
    // R8 max and min
    ta = '{0, 0, 0, 0, 0, 0, 0, 0};
    td = '{300, 7, 65535, 42, 0, 9, 1000, 12};
    round("R8", 4, 1'b0);
    round("R8", 5, 1'b0);

    // R3 invalid requests do not write
    tv = 8'b1010_0101;
    ta = '{40, 50, 40, 60, 70, 70, 80, 90};
    td = '{1, 2, 3, 4, 5, 6, 7, 8};
    round("R3", 0, 1'b0);

    // R9 no writes at all
    tv = '0;
    round("R9", 0, 1'b0);
    tv = '1;
    ta = '{3, 3, 3, 3, 3, 3, 3, 3};
    td = '{1, 1, 1, 1, 1, 1, 1, 2};
    round("R9", 1, 1'b0);
    round("R6", 2, 1'b0);

    // R10 start while busy is ignored
    ta = '{8, 4, 8, 2, 4, 8, 1, 0};
    td = '{5, 6, 7, 8, 9, 10, 11, 12};
    round("R10", 0, 1'b1);
    round("R10", 1, 1'b1);

    for (int r = 0; r < 40; r++) begin
      tv = P'($urandom);
      for (int i = 0; i < P; i++) begin
        ta[i] = int'($urandom % 4);
        td[i] = int'($urandom % 4) * 1000 + 40000;
      end
      round("R3", int'($urandom % 8), r[0]);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule